// File: doc/BRIEF.md
# Descriptor Ring Pointer Unit with Interrupt Coalescing

This unit keeps the control state of one circular descriptor ring that hardware fills and software drains, such as a receive-done or a transmit-reclaim queue. It holds the ring's base address, its size in descriptors, a producer pointer that hardware advances and a consumer pointer that software writes. Both pointers are byte offsets into a ring of 32-byte descriptors. A completion pulse from the datapath moves the producer pointer one descriptor forward. The unit derives the number of descriptors waiting, together with full and empty flags.

To limit interrupt traffic, the unit sets a sticky "entries arrived" flag only after a programmable number of completions. A second sticky flag is set when entries stay unconsumed for a programmable number of cycles. A third flag records completions that were dropped because the ring was full. The flags are cleared by writing ones, and they are masked into a single interrupt line. Base, size and consumer pointer can change only while their own bit is set in a write-unlock register, so a stray write cannot corrupt a running ring.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset: base 0, ring size 2^IDX_W descriptors, both pointers 0, empty 1, full 0, count 0, status 0, irq 0, count threshold 1, timeout 0 (off), irq enables 0, unlock bits 0.
- R2: Register addresses: 0 base, 1 size, 2 consumer pointer, 3 unlock, 4 count threshold, 5 timeout, 6 irq enable, 7 status clear. A write to address 0, 1 or 2 takes effect only if unlock bit 2, 1 or 0 respectively is set. Otherwise it is ignored. Writes to addresses 3 to 7 always take effect.
- R3: Pointers are byte offsets, with index = pointer >> 5. Each accepted completion adds 32 to the producer pointer, modulo size*32. A consumer-pointer write stores bits [IDX_W+4:5] masked by size-1, and its low 5 bits read back as 0.
- R4: A size write carries the descriptor count in bits [IDX_W+3:3]. It is accepted only if that count is a power of two, and it then returns both pointers to 0. Any other value is ignored.
- R5: The valid count equals (producer index - consumer index) mod size.
- R6: Empty is 1 when the indices are equal. Full is 1 when (producer index + 1) mod size equals the consumer index.
- R7: A completion that arrives while the ring is full leaves the producer pointer unchanged and sets status bit 2.
- R8: Status bit 0 sets on the edge where the number of accepted completions since it last fired reaches a nonzero threshold. That count then restarts from 0. A threshold of 0 never fires.
- R9: A wait counter restarts on an accepted completion, on an accepted consumer write, or while the ring is empty. Otherwise, with a nonzero timeout T, status bit 1 sets on the T-th consecutive counting edge, and the counter then restarts.
- R10: Status bits are sticky. Writing 1 to a bit at address 7 clears it, but a set in the same cycle wins over the clear.
- R11: irq is 1 exactly when some status bit and its enable bit (address 6, same bit position) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| done_i | input | 1 | Datapath completed one descriptor |
| ring_base_o | output | 32 | Ring base address |
| ring_size_o | output | IDX_W+1 | Ring size in descriptors |
| hw_ptr_o | output | IDX_W+5 | Producer pointer, bytes |
| sw_ptr_o | output | IDX_W+5 | Consumer pointer, bytes |
| valid_cnt_o | output | IDX_W | Descriptors waiting |
| full_o | output | 1 | Ring full |
| empty_o | output | 1 | Ring empty |
| status_o | output | 3 | Sticky flags: 0 count, 1 timeout, 2 overflow |
| irq_o | output | 1 | Masked interrupt |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a completion pulse and a consumer-pointer write, which changes both indices, the count and the wait counter at once. The second pair is a flag being set and a write-one clear of that same bit. The bench forces both pairs with directed cycles. A long pseudo-random phase then mixes completions, clears and register writes freely. A behavioural model that keeps plain integer indices judges every cycle, so any wrong priority shows up in the pointers, the count or the status bits on the following edge.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int DESC_SHIFT = 5;
  localparam int SIZE_SHIFT = 3;

  typedef enum logic [2:0] {
    RA_BASE = 3'd0, RA_SIZE = 3'd1, RA_SWPTR = 3'd2, RA_UNLOCK = 3'd3,
    RA_THRESH = 3'd4, RA_TMO = 3'd5, RA_IEN = 3'd6, RA_ICLR = 3'd7
  } ring_addr_e;

  localparam int ST_FILL = 0;
  localparam int ST_TMO  = 1;
  localparam int ST_OVF  = 2;

  function automatic int unsigned ring_next(int unsigned idx, int unsigned size);
    return (idx + 1) & (size - 1);
  endfunction

  function automatic int unsigned ring_used(int unsigned prod, int unsigned cons,
                                            int unsigned size);
    return (prod - cons) & (size - 1);
  endfunction

  function automatic logic is_pow2(int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs #(
  parameter int IDX_W = 4,
  parameter int THR_W = 5,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      base_q,
  output logic [IDX_W:0]   size_q,
  output logic [THR_W-1:0] thr_q,
  output logic [TMO_W-1:0] tmo_q,
  output logic [2:0]       ien_q,
  output logic             size_wr_o,
  output logic             swptr_wr_o,
  output logic [2:0]       clr_o
);
  import ring_pkg::*;

  logic [2:0]     unlock_q;
  logic [IDX_W:0] size_cand;

  assign size_cand  = wdata[IDX_W+SIZE_SHIFT:SIZE_SHIFT];
  assign size_wr_o  = we && (addr == RA_SIZE) && unlock_q[1]
                      && is_pow2(32'(size_cand));
  assign swptr_wr_o = we && (addr == RA_SWPTR) && unlock_q[0];
  assign clr_o      = (we && addr == RA_ICLR) ? wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      size_q   <= (IDX_W+1)'(1 << IDX_W);
      thr_q    <= THR_W'(1);
      tmo_q    <= '0;
      ien_q    <= '0;
      unlock_q <= '0;
    end else if (we) begin
      unique case (addr)
        RA_BASE:   if (unlock_q[2]) base_q <= wdata;
        RA_SIZE:   if (size_wr_o) size_q <= size_cand;
        RA_UNLOCK: unlock_q <= wdata[2:0];
        RA_THRESH: thr_q <= wdata[THR_W-1:0];
        RA_TMO:    tmo_q <= wdata[TMO_W-1:0];
        RA_IEN:    ien_q <= wdata[2:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/ring_ptr_track.sv
module ring_ptr_track #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W:0]   size,
  input  logic             done,
  input  logic             size_wr,
  input  logic             swptr_wr,
  input  logic [IDX_W-1:0] swptr_idx,
  output logic [IDX_W-1:0] hw_idx,
  output logic [IDX_W-1:0] sw_idx,
  output logic [IDX_W-1:0] used,
  output logic             full,
  output logic             empty,
  output logic             accept,
  output logic             drop
);
  import ring_pkg::*;

  logic [IDX_W-1:0] mask;

  assign mask   = IDX_W'(32'(size) - 1);
  assign used   = IDX_W'(ring_used(32'(hw_idx), 32'(sw_idx), 32'(size)));
  assign empty  = (hw_idx == sw_idx);
  assign full   = (IDX_W'(ring_next(32'(hw_idx), 32'(size))) == sw_idx);
  assign accept = done && !full;
  assign drop   = done && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_idx <= '0;
      sw_idx <= '0;
    end else if (size_wr) begin
      hw_idx <= '0;
      sw_idx <= '0;
    end else begin
      if (accept)   hw_idx <= IDX_W'(ring_next(32'(hw_idx), 32'(size)));
      if (swptr_wr) sw_idx <= swptr_idx & mask;
    end
  end
endmodule

// File: rtl/ring_irq_coalesce.sv
module ring_irq_coalesce #(
  parameter int THR_W = 5,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             drop,
  input  logic             swptr_wr,
  input  logic             empty,
  input  logic [THR_W-1:0] thr,
  input  logic [TMO_W-1:0] tmo,
  input  logic [2:0]       clr,
  input  logic [2:0]       ien,
  output logic [2:0]       status,
  output logic             irq,
  output logic             fill_hit,
  output logic             tmo_hit
);
  import ring_pkg::*;

  logic [THR_W-1:0] pend_q;
  logic [TMO_W-1:0] wait_q;
  logic             wait_rst;
  logic [2:0]       set_v;

  assign fill_hit = accept && (thr != '0) && ({1'b0, pend_q} + 1'b1 >= {1'b0, thr});
  assign wait_rst = accept || swptr_wr || empty;
  assign tmo_hit  = !wait_rst && (tmo != '0) && ({1'b0, wait_q} + 1'b1 >= {1'b0, tmo});

  always_comb begin
    set_v          = '0;
    set_v[ST_FILL] = fill_hit;
    set_v[ST_TMO]  = tmo_hit;
    set_v[ST_OVF]  = drop;
  end

  assign irq = |(status & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      wait_q <= '0;
      status <= '0;
    end else begin
      status <= (status & ~clr) | set_v;
      if (fill_hit)                          pend_q <= '0;
      else if (accept && (pend_q != '1))     pend_q <= pend_q + 1'b1;
      if (wait_rst || tmo_hit)               wait_q <= '0;
      else if (wait_q != '1)                 wait_q <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl #(
  parameter int IDX_W = 4,
  parameter int TMO_W = 20,
  localparam int THR_W = IDX_W + 1,
  localparam int PTR_W = IDX_W + ring_pkg::DESC_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             done_i,
  output logic [31:0]      ring_base_o,
  output logic [IDX_W:0]   ring_size_o,
  output logic [PTR_W-1:0] hw_ptr_o,
  output logic [PTR_W-1:0] sw_ptr_o,
  output logic [IDX_W-1:0] valid_cnt_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [2:0]       status_o,
  output logic             irq_o
);
  import ring_pkg::*;

  logic [THR_W-1:0] thr;
  logic [TMO_W-1:0] tmo;
  logic [2:0]       ien, clr;
  logic             size_wr, swptr_wr, accept, drop, fill_hit, tmo_hit;
  logic [IDX_W-1:0] hw_idx, sw_idx;

  ring_cfg_regs #(.IDX_W(IDX_W), .THR_W(THR_W), .TMO_W(TMO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .base_q(ring_base_o), .size_q(ring_size_o), .thr_q(thr), .tmo_q(tmo),
    .ien_q(ien), .size_wr_o(size_wr), .swptr_wr_o(swptr_wr), .clr_o(clr)
  );

  ring_ptr_track #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .size(ring_size_o), .done(done_i),
    .size_wr(size_wr), .swptr_wr(swptr_wr),
    .swptr_idx(reg_wdata[IDX_W+DESC_SHIFT-1:DESC_SHIFT]),
    .hw_idx(hw_idx), .sw_idx(sw_idx), .used(valid_cnt_o),
    .full(full_o), .empty(empty_o), .accept(accept), .drop(drop)
  );

  ring_irq_coalesce #(.THR_W(THR_W), .TMO_W(TMO_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .drop(drop), .swptr_wr(swptr_wr),
    .empty(empty_o), .thr(thr), .tmo(tmo), .clr(clr), .ien(ien),
    .status(status_o), .irq(irq_o), .fill_hit(fill_hit), .tmo_hit(tmo_hit)
  );

  assign hw_ptr_o = {hw_idx, {DESC_SHIFT{1'b0}}};
  assign sw_ptr_o = {sw_idx, {DESC_SHIFT{1'b0}}};
endmodule

// File: rtl/ring_ctrl_chk.sv
module ring_ctrl_chk #(
  parameter int IDX_W = 4,
  parameter int PTR_W = IDX_W + 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             done_i,
  input logic [IDX_W:0]   ring_size_o,
  input logic [PTR_W-1:0] hw_ptr_o,
  input logic [IDX_W-1:0] valid_cnt_o,
  input logic             full_o,
  input logic             empty_o,
  input logic [2:0]       status_o,
  input logic             irq_o,
  input logic             accept,
  input logic             drop
);
  logic size_try;
  assign size_try = reg_we && (reg_addr == 3'd1);

  // R6
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_size_o > 1) |-> !(full_o && empty_o));

  // R5
  empty_zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (valid_cnt_o == '0));

  // R7
  full_drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !size_try) |=> ($stable(hw_ptr_o) && status_o[2]));

  // R3
  accept_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !size_try) |=> (hw_ptr_o != $past(hw_ptr_o)));

  // R10
  fill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && !(reg_we && reg_addr == 3'd7 && reg_wdata[0])) |=> status_o[0]);

  // R11
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 3'b000) |-> !irq_o);

  // R7
  done_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (accept != drop));
endmodule

bind desc_ring_ctrl ring_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .done_i(done_i), .ring_size_o(ring_size_o),
  .hw_ptr_o(hw_ptr_o), .valid_cnt_o(valid_cnt_o), .full_o(full_o),
  .empty_o(empty_o), .status_o(status_o), .irq_o(irq_o),
  .accept(accept), .drop(drop)
);

// File: tb/desc_ring_ctrl_tb.sv
module desc_ring_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDX = 4;
  localparam int PW = IDX + 5;
  localparam int THRMAX = (1 << (IDX + 1)) - 1;
  localparam int TMOMAX = (1 << 20) - 1;

  logic clk = 0, rst_n = 0, reg_we = 0, done_i = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] ring_base_o;
  logic [IDX:0] ring_size_o;
  logic [PW-1:0] hw_ptr_o, sw_ptr_o;
  logic [IDX-1:0] valid_cnt_o;
  logic full_o, empty_o, irq_o;
  logic [2:0] status_o;

  int n_run = 0, n_fail = 0;
  bit running = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring_ctrl #(.IDX_W(IDX)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .done_i(done_i), .ring_base_o(ring_base_o),
    .ring_size_o(ring_size_o), .hw_ptr_o(hw_ptr_o), .sw_ptr_o(sw_ptr_o),
    .valid_cnt_o(valid_cnt_o), .full_o(full_o), .empty_o(empty_o),
    .status_o(status_o), .irq_o(irq_o)
  );

  task automatic check_eq(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: plain integer ring indices
  logic [31:0] m_base;
  int m_size, m_hw, m_sw, m_unl, m_thr, m_tmo, m_ien, m_st, m_pend, m_wait;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_size = 1 << IDX; m_hw = 0; m_sw = 0; m_unl = 0;
      m_thr = 1; m_tmo = 0; m_ien = 0; m_st = 0; m_pend = 0; m_wait = 0;
    end else begin
      int wa, cand, setv, clrv;
      bit full, empty, acc, drp, swr, szw;
      full  = (((m_hw + 1) % m_size) == m_sw);
      empty = (m_hw == m_sw);
      acc = done_i && !full;
      drp = done_i && full;
      wa = reg_we ? int'(reg_addr) : -1;
      cand = int'((reg_wdata >> 3) & THRMAX);
      szw = (wa == 1) && m_unl[1] && cand != 0 && (cand & (cand - 1)) == 0;
      swr = (wa == 2) && m_unl[0];
      setv = 0;
      if (acc) begin
        if (m_thr != 0 && m_pend + 1 >= m_thr) begin setv |= 1; m_pend = 0; end
        else if (m_pend < THRMAX) m_pend++;
      end
      if (acc || swr || empty) m_wait = 0;
      else if (m_tmo != 0 && m_wait + 1 >= m_tmo) begin setv |= 2; m_wait = 0; end
      else if (m_wait < TMOMAX) m_wait++;
      if (drp) setv |= 4;
      clrv = (wa == 7) ? int'(reg_wdata & 7) : 0;
      m_st = ((m_st & ~clrv) | setv) & 7;
      if (acc) m_hw = (m_hw + 1) % m_size;
      if (swr) m_sw = int'(reg_wdata >> 5) % m_size;
      if (szw) begin m_size = cand; m_hw = 0; m_sw = 0; end
      if (wa == 0 && m_unl[2]) m_base = reg_wdata;
      if (wa == 3) m_unl = int'(reg_wdata & 7);
      if (wa == 4) m_thr = int'(reg_wdata & THRMAX);
      if (wa == 5) m_tmo = int'(reg_wdata & TMOMAX);
      if (wa == 6) m_ien = int'(reg_wdata & 7);
    end
  end

  always @(negedge clk) begin
    if (running && rst_n) begin
      int used;
      used = (m_hw - m_sw + m_size) % m_size;
      check_eq("R2 base", ring_base_o, m_base);
      check_eq("R4 size", ring_size_o, m_size);
      check_eq("R3 hw_ptr", hw_ptr_o, m_hw * 32);
      check_eq("R3 sw_ptr", sw_ptr_o, m_sw * 32);
      check_eq("R5 count", valid_cnt_o, used);
      check_eq("R6 empty", empty_o, m_hw == m_sw);
      check_eq("R6 full", full_o, ((m_hw + 1) % m_size) == m_sw);
      check_eq("R8 fill flag", status_o[0], m_st & 1);
      check_eq("R9 timeout flag", status_o[1], (m_st >> 1) & 1);
      check_eq("R7 overflow flag", status_o[2], (m_st >> 2) & 1);
      check_eq("R10 status", status_o, m_st);
      check_eq("R11 irq", irq_o, (m_st & m_ien) != 0);
    end
  end

  task automatic cyc(bit we, int a, logic [31:0] d, bit dn);
    reg_we = we; reg_addr = 3'(a); reg_wdata = d; done_i = dn;
    @(negedge clk);
    reg_we = 0; done_i = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    cyc(1, a, d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 base", ring_base_o, 0);
    check_eq("R1 size", ring_size_o, 16);
    check_eq("R1 hw_ptr", hw_ptr_o, 0);
    check_eq("R1 sw_ptr", sw_ptr_o, 0);
    check_eq("R1 empty", empty_o, 1);
    check_eq("R1 full", full_o, 0);
    check_eq("R1 status", status_o, 0);
    check_eq("R1 irq", irq_o, 0);
    running = 1;
    // R2 locked writes ignored
    wr(0, 32'h0000_4000); wr(1, 8 << 3); wr(2, 3 << 5);
    check_eq("R2 locked base", ring_base_o, 0);
    check_eq("R2 locked size", ring_size_o, 16);
    wr(3, 7); wr(0, 32'h0000_1000); wr(1, 8 << 3);
    check_eq("R4 size eight", ring_size_o, 8);
    wr(6, 7); wr(4, 3); wr(5, 6);
    // R8 threshold of three
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    check_eq("R8 below threshold", status_o[0], 0);
    cyc(0, 0, 0, 1);
    check_eq("R8 threshold hit", status_o[0], 1);
    check_eq("R11 irq raised", irq_o, 1);
    wr(7, 1);
    // R9 idle wait
    repeat (8) cyc(0, 0, 0, 0);
    check_eq("R9 timeout fired", status_o[1], 1);
    // completion and consumer write together
    cyc(1, 2, 2 << 5, 1);
    check_eq("R5 joint update", valid_cnt_o, 2);
    // fill to full, then overflow
    repeat (7) cyc(0, 0, 0, 1);
    check_eq("R6 full reached", full_o, 1);
    cyc(0, 0, 0, 1);
    check_eq("R7 dropped", status_o[2], 1);
    // clear colliding with a new overflow: set wins
    cyc(1, 7, 7, 1);
    check_eq("R10 set beats clear", status_o[2], 1);
    // R3 wrap with size four, R4 bad size ignored
    wr(1, 4 << 3); wr(1, 5 << 3);
    check_eq("R4 bad size ignored", ring_size_o, 4);
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 1);
      cyc(1, 2, hw_ptr_o | 5'h1f, 0);
    end
    wr(4, 0);
    repeat (5) cyc(0, 0, 0, 1);
    // random phase
    lfsr = 32'h1ACE5;
    for (int i = 0; i < 4000; i++) begin
      int r, a;
      logic [31:0] d;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
      r = lfsr & 32'h7fff_ffff;
      a = (r >> 4) % 8;
      case (a)
        1: d = (1 << ((r >> 8) % 5)) << 3;
        2: d = 32'(r >> 3);
        3: d = ((r >> 9) % 8 == 0) ? 32'd0 : 32'd7;
        4: d = (r >> 8) % 5;
        5: d = (r >> 8) % 12;
        default: d = 32'(r >> 7);
      endcase
      cyc(((r >> 1) % 4) == 0, a, d, r[0] | r[2]);
    end
    running = 0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule